// File: doc/BRIEF.md
# Hold-Mode Line-Buffered DRAM Read Port

This block lets an external bus master read the chip's internal DRAM while the chip has handed over its bus. The master requests hold with an active-low input, and the block grants it one clock later on an active-low acknowledge. During the grant, the master drives chip select low and read/write high and presents a halfword address. The block then returns the 16-bit halfword. An active-low completion strobe marks when the data is valid, and the master keeps select low until it has seen that strobe.

A 128-bit line buffer holds the aligned group of eight halfwords that contains the most recently fetched address. On a miss the block reads the whole line from a DRAM model. The model has a fixed, parameterised latency and computes its contents from the address. On a hit the halfword comes from the buffer in one clock. Write cycles get no response, and neither do accesses outside a hold grant. A change of select, address, direction or hold request during the wait cycles aborts the access and sets a sticky protocol-error flag.

Top module: `hold_rd_port`

## Requirements
- R1: `hold_ack_n` equals the value `hold_req_n` had at the previous clock edge. An access is recognised only while `hold_ack_n` is low and `hold_req_n` is still low.
- R2: A completed read drives on `dbus` the model DRAM word for halfword address A, which is `{A[7:0], ~A[15:8]} ^ {9'b0, A[22:16]}`. The `byte_ctl_n` inputs have no effect on this data.
- R3: A read whose line (address bits above bit 2) is not in the buffer makes `done_n` fall at the FETCH_LAT-th rising edge that samples the request. `done_n` stays high on all earlier edges, and the line is loaded into the buffer at that same edge.
- R4: A read to a line that is valid in the buffer makes `done_n` fall at the first edge that samples the request. The three lowest address bits select the halfword within the line.
- R5: After completion, `done_n` stays low and the data stays driven while `cs_n` stays low. Both are released at the first edge that samples `cs_n` high.
- R6: `dbus_oe` is high exactly when `done_n` is low. `dbus` is zero whenever `dbus_oe` is low.
- R7: A cycle with `rd_wr` low, or a select arriving without a hold grant, leaves `done_n` high and `dbus_oe` low.
- R8: During the wait cycles, any of the following aborts the access without loading the buffer: `cs_n` going high, `addr` or `rd_wr` changing, or `hold_req_n` going high. The same holds if hold is released while select is still low after completion. In each case `proto_err` goes high at the next edge and stays high until the next hold grant clears it.
- R9: Releasing hold invalidates the line buffer, so the first read of any line after a new grant is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold_req_n | input | 1 | Bus hold request from external master, active low |
| hold_ack_n | output | 1 | Hold granted, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | Direction, high for read |
| addr | input | ADDR_W | Halfword address |
| byte_ctl_n | input | 2 | Byte lane controls, unused for reads |
| dbus | output | 16 | Read data |
| dbus_oe | output | 1 | Data bus output enable (bus released when low) |
| done_n | output | 1 | Access complete, active low |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The bound checker watches the following on every clock: that the acknowledge tracks the request, that completion happens only under a grant, and that the output enable stays tied to the completion strobe with a quiet bus. It also checks the miss latency through a cycle counter, single-cycle completion for hits, completion being held while select stays low, write cycles getting no response, and the error flag after select rises mid-fetch. The correctness of the returned halfword, the effect of invalidation across hold sessions, the fact that an aborted fetch loads nothing, and the error being cleared by the next grant can only be shown by the bench's scenarios. The bench shows these by comparing every output against its behavioural model on each clock.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int HW_W    = 16;
    localparam int LINE_HW = 8;
    localparam int IDX_W   = $clog2(LINE_HW);
    localparam int LINE_W  = HW_W * LINE_HW;
    localparam int MODEL_AW = 23;

    typedef logic [HW_W-1:0] hword_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_DONE  = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic   drive;
        hword_t data;
    } bus_out_t;

    // Contents of the modelled DRAM, derived from the halfword address.
    function automatic hword_t dram_word(input logic [MODEL_AW-1:0] a);
        return {a[7:0], ~a[15:8]} ^ {9'b0, a[22:16]};
    endfunction

endpackage

// File: rtl/hrp_hold_ctl.sv
module hrp_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic hold_req_n,
    output logic hold_ack_n,
    output logic grant,
    output logic release_p
);
    logic ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b1;
        else     ack_q <= hold_req_n;
    end

    assign hold_ack_n = ack_q;
    assign grant      = ack_q & ~hold_req_n;
    assign release_p  = ~ack_q & hold_req_n;
endmodule

// File: rtl/hrp_dram_model.sv
module hrp_dram_model
    import hrp_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int FETCH_LAT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    abort,
    input  logic [ADDR_W-IDX_W-1:0] start_tag,
    output logic                    rdy,
    output logic [LINE_W-1:0]       line
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int CNT_W = $clog2(FETCH_LAT + 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [TAG_W-1:0] tag_q;

    assign rdy = busy && (cnt == CNT_W'(FETCH_LAT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            tag_q <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(1);
            tag_q <= start_tag;
        end else if (busy) begin
            if (rdy) busy <= 1'b0;
            else     cnt  <= cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < LINE_HW; i++) begin : g_word
        assign line[i*HW_W +: HW_W] = dram_word(MODEL_AW'({tag_q, IDX_W'(i)}));
    end
endmodule

// File: rtl/hrp_line_buf.sv
module hrp_line_buf
    import hrp_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              inval,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic [LINE_W-1:0] load_line,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [IDX_W-1:0]  look_idx,
    output logic              hit,
    output hword_t            rd_word
);
    logic             valid;
    logic [TAG_W-1:0] tag_q;
    hword_t           mem [LINE_HW];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag_q <= '0;
            for (int i = 0; i < LINE_HW; i++) mem[i] <= '0;
        end else if (inval) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            tag_q <= load_tag;
            for (int i = 0; i < LINE_HW; i++) mem[i] <= load_line[i*HW_W +: HW_W];
        end
    end

    assign hit     = valid && (tag_q == look_tag);
    assign rd_word = mem[look_idx];
endmodule

// File: rtl/hold_rd_port.sv
module hold_rd_port
    import hrp_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int FETCH_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_req_n,
    output logic              hold_ack_n,
    input  logic              cs_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        byte_ctl_n,
    output logic [HW_W-1:0]   dbus,
    output logic              dbus_oe,
    output logic              done_n,
    output logic              proto_err
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic grant, rel, held;
    logic req, hit, fetch_rdy, start, abort, load, viol, err_set;
    logic [ADDR_W-1:0] lat_addr;
    logic [LINE_W-1:0] fetch_line;
    hword_t buf_word, fetch_word;
    acc_state_e state, state_nx;
    bus_out_t bus_q, bus_nx;
    logic done_nx;
    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx, lat_idx;

    // Byte lanes play no part in reads.
    logic unused_byte_ctl;
    assign unused_byte_ctl = ^byte_ctl_n;

    hrp_hold_ctl u_hold (
        .clk(clk), .rst(rst), .hold_req_n(hold_req_n),
        .hold_ack_n(hold_ack_n), .grant(grant), .release_p(rel)
    );

    assign held    = ~hold_ack_n;
    assign req_tag = addr[ADDR_W-1:IDX_W];
    assign req_idx = addr[IDX_W-1:0];
    assign lat_idx = lat_addr[IDX_W-1:0];
    assign req     = held & ~hold_req_n & ~cs_n & rd_wr;
    assign viol    = cs_n | hold_req_n | ~rd_wr | (addr != lat_addr);
    assign start   = (state == S_IDLE) && req && !hit;
    assign abort   = (state == S_FETCH) && viol;
    assign load    = (state == S_FETCH) && fetch_rdy && !viol;
    assign err_set = abort || ((state == S_DONE) && hold_req_n && !cs_n);

    hrp_dram_model #(.ADDR_W(ADDR_W), .FETCH_LAT(FETCH_LAT)) u_dram (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .start_tag(req_tag), .rdy(fetch_rdy), .line(fetch_line)
    );

    hrp_line_buf #(.TAG_W(TAG_W)) u_buf (
        .clk(clk), .rst(rst), .load(load), .inval(rel),
        .load_tag(lat_addr[ADDR_W-1:IDX_W]), .load_line(fetch_line),
        .look_tag(req_tag), .look_idx(req_idx),
        .hit(hit), .rd_word(buf_word)
    );

    assign fetch_word = fetch_line[lat_idx*HW_W +: HW_W];

    always_comb begin
        state_nx = state;
        bus_nx   = bus_q;
        done_nx  = done_n;
        unique case (state)
            S_IDLE: begin
                if (req) begin
                    if (hit) begin
                        state_nx     = S_DONE;
                        bus_nx.drive = 1'b1;
                        bus_nx.data  = buf_word;
                        done_nx      = 1'b0;
                    end else begin
                        state_nx = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                if (viol) begin
                    state_nx = S_IDLE;
                end else if (fetch_rdy) begin
                    state_nx     = S_DONE;
                    bus_nx.drive = 1'b1;
                    bus_nx.data  = fetch_word;
                    done_nx      = 1'b0;
                end
            end
            S_DONE: begin
                if (cs_n || hold_req_n) begin
                    state_nx = S_IDLE;
                    bus_nx   = '0;
                    done_nx  = 1'b1;
                end
            end
            default: begin
                state_nx = S_IDLE;
                bus_nx   = '0;
                done_nx  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            bus_q     <= '0;
            done_n    <= 1'b1;
            lat_addr  <= '0;
            proto_err <= 1'b0;
        end else begin
            state  <= state_nx;
            bus_q  <= bus_nx;
            done_n <= done_nx;
            if (start) lat_addr <= addr;
            if (grant)        proto_err <= 1'b0;
            else if (err_set) proto_err <= 1'b1;
        end
    end

    assign dbus    = bus_q.data;
    assign dbus_oe = bus_q.drive;
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker
    import hrp_pkg::*;
#(
    parameter int FETCH_LAT = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       hold_req_n,
    input logic       hold_ack_n,
    input logic       cs_n,
    input logic       rd_wr,
    input logic       done_n,
    input logic       dbus_oe,
    input hword_t     dbus,
    input logic       proto_err,
    input logic       req,
    input logic       hit,
    input logic       fetch_rdy,
    input acc_state_e state
);
    logic [15:0] fcnt;

    always_ff @(posedge clk) begin
        if (rst)                   fcnt <= '0;
        else if (state == S_FETCH) fcnt <= fcnt + 1'b1;
        else                       fcnt <= '0;
    end

    p_ack_follows_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> hold_ack_n == $past(hold_req_n));

    p_done_in_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !done_n |-> !hold_ack_n);

    p_miss_lat_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH && fetch_rdy) |-> fcnt == 16'(FETCH_LAT - 2));

    p_hit_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && req && hit) |=> !done_n);

    p_done_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (!done_n && !cs_n && !hold_req_n) |=> !done_n);

    p_oe_match_r6: assert property (@(posedge clk) disable iff (rst)
        dbus_oe == !done_n);

    p_bus_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !dbus_oe |-> dbus == '0);

    p_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !rd_wr) |=> done_n);

    p_err_cs_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH && cs_n) |=> proto_err);
endmodule

bind hold_rd_port hrp_checker #(.FETCH_LAT(FETCH_LAT)) u_chk (
    .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
    .cs_n(cs_n), .rd_wr(rd_wr), .done_n(done_n), .dbus_oe(dbus_oe),
    .dbus(dbus), .proto_err(proto_err), .req(req), .hit(hit),
    .fetch_rdy(fetch_rdy), .state(state)
);

// File: tb/test_hold_rd_port.sv
module test_hold_rd_port;
    localparam int AW  = 23;
    localparam int LAT = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          hold_req_n = 1'b1;
    logic          hold_ack_n;
    logic          cs_n = 1'b1;
    logic          rd_wr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    byte_ctl_n = 2'b00;
    logic [15:0]   dbus;
    logic          dbus_oe, done_n, proto_err;

    hold_rd_port #(.ADDR_W(AW), .FETCH_LAT(LAT)) i_hold_rd_port (
        .clk(clk), .rst(rst), .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n),
        .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr), .byte_ctl_n(byte_ctl_n),
        .dbus(dbus), .dbus_oe(dbus_oe), .done_n(done_n), .proto_err(proto_err)
    );

    int checks = 0;
    int fails  = 0;
    bit chk_on = 0;
    bit finished = 0;
    string cur_req = "R5";

    // Expected outputs after the latest edge.
    logic        e_ack_n = 1'b1, e_done_n = 1'b1, e_oe = 1'b0, e_err = 1'b0;
    logic [15:0] e_data = '0;

    // Behavioural view of the line buffer.
    bit m_valid = 0;
    int m_line  = 0;

    function automatic logic [15:0] ref_word(int a);
        logic [22:0] v;
        v = a[22:0];
        return {v[7:0], ~v[15:8]} ^ {9'b0, v[22:16]};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            chk(hold_ack_n == e_ack_n, "R1", "hold_ack_n", hold_ack_n, e_ack_n);
            chk(done_n == e_done_n, cur_req, "done_n", done_n, e_done_n);
            chk(dbus_oe == e_oe, "R6", "dbus_oe", dbus_oe, e_oe);
            chk(dbus == e_data, "R2", "dbus", dbus, e_data);
            chk(proto_err == e_err, "R8", "proto_err", proto_err, e_err);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic grant_hold();
        hold_req_n = 1'b0;
        tick();
        e_ack_n = 1'b0;
        e_err   = 1'b0;
    endtask

    task automatic release_hold();
        hold_req_n = 1'b1;
        tick();
        e_ack_n = 1'b1;
        m_valid = 0;   // R9 buffer invalidated
    endtask

    task automatic rd(int a, int keep);
        bit hit;
        hit = m_valid && (m_line == (a >> 3));
        cur_req = hit ? "R4" : "R3";
        cs_n = 1'b0; rd_wr = 1'b1; addr = a[AW-1:0];
        if (!hit) begin
            repeat (LAT - 1) begin
                tick();
                e_done_n = 1'b1;
            end
        end
        tick();
        e_done_n = 1'b0; e_oe = 1'b1; e_data = ref_word(a);
        m_valid = 1; m_line = a >> 3;
        cur_req = "R5";
        for (int k = 0; k < keep; k++) begin
            byte_ctl_n = byte_ctl_n + 2'd1;   // R2 byte lanes ignored
            tick();
        end
        cs_n = 1'b1;
        tick();
        e_done_n = 1'b1; e_oe = 1'b0; e_data = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk_on = 1;
        tick();

        // R7: select without a hold grant gets no response
        cur_req = "R7";
        cs_n = 1'b0; addr = 23'h5;
        repeat (4) tick();
        cs_n = 1'b1;
        tick();

        // R1: grant
        grant_hold();
        tick();

        // R7: write cycle under grant is ignored
        cur_req = "R7";
        cs_n = 1'b0; rd_wr = 1'b0; addr = 23'h40;
        repeat (4) tick();
        cs_n = 1'b1; rd_wr = 1'b1;
        tick();

        // R3 miss, then R4 hits across every halfword of the line, R2 byte lanes toggled
        rd(32'h40, 1);
        for (int i = 1; i < 8; i++) rd(32'h40 + i, 1);
        rd(32'h40, 0);
        // R5: completion held while select stays low
        rd(32'h47, 4);
        // R4 boundary: next line is a miss
        rd(32'h48, 0);
        rd(32'h4F, 0);
        // R3 high address, then R4 hit in same line
        rd(32'h7ABCDE, 0);
        rd(32'h7ABCD9, 2);

        // R8: select rises mid-fetch
        cs_n = 1'b0; rd_wr = 1'b1; addr = 23'h100;
        tick();
        cs_n = 1'b1;
        tick();
        e_err = 1'b1;
        tick();
        // R8: aborted fetch did not load; old line still hits
        rd(32'h7ABCD8, 0);

        // R8: address change mid-fetch
        cs_n = 1'b0; addr = 23'h200;
        tick();
        addr = 23'h300;
        tick();
        rd(32'h300, 0);

        // R8 flag survives release, cleared by next grant
        release_hold();
        tick();
        grant_hold();
        tick();

        // R9: same line misses after new session
        rd(32'h301, 0);
        rd(32'h302, 0);

        // R1: after release, select is ignored again
        release_hold();
        cur_req = "R7";
        cs_n = 1'b0; addr = 23'h302;
        repeat (3) tick();
        cs_n = 1'b1;
        tick();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule